// File: doc/BRIEF.md
# Flash Program and Erase Engine

This block is the internal write engine of a byte-wide NOR flash model placed over a small synchronous memory. A command decoder sends it either a single-byte program request (address and data) or a whole-array erase request. The engine times each operation with an internal cycle counter and then updates the array. A program can only clear bits. An erase sets every unprotected location back to all ones.

While an operation runs, the active-low `busy_n` output is held low. A read during that time returns a status byte instead of array data. In the status byte, bit 7 is the inverse of the target value's bit 7, and bit 6 flips on every read. A boot region at one end of the array can be locked. When it is locked, programs to it are dropped and erases skip it. An override input removes the lock for as long as it is held. Operation lengths and the array depth are parameters. The boot region is one sixty-fourth of the array, placed at the bottom or at the top as a parameter selects.

Top module: `nwe_engine`

## Requirements
- R1: A completed program stores the old byte AND the request data at the request address, so bits only go from 1 to 0.
- R2: A completed erase leaves 0xFF in every location that is not blocked by the boot lock.
- R3: A read issued while busy returns a status byte. Bit 7 is the inverse of bit 7 of the program data, or 0 during an erase. Bits 5..0 are zero.
- R4: Bit 6 of the status byte inverts on every read issued while busy. It starts at 0 after reset and keeps its value across operations.
- R5: `busy_n` goes low in the cycle after a request is accepted. It stays low for PROG_CYC cycles for a program, and for ERASE_CYC plus the array depth for an erase.
- R6: `done` is high for exactly one cycle, which is the first cycle in which `busy_n` is high again.
- R7: The boot region is the lowest DEPTH/64 addresses when TOP_BOOT is 0, and the highest DEPTH/64 addresses when TOP_BOOT is 1. With `lock_en` high and `lock_ovr` low, a program to that region starts nothing (no busy, no done, byte unchanged), and an erase leaves the region unchanged.
- R8: With `lock_ovr` high, the boot region is programmed and erased like any other address.
- R9: Requests that arrive while busy are ignored. When `prog_req` and `erase_req` are both high in the same idle cycle, the program is taken.
- R10: A low `rst_n` aborts any operation at once, returns to idle with `busy_n` high and `done` low, clears `rd_data`, and clears the bit 6 state.
- R11: While idle, a read returns the array byte at `rd_addr` one cycle after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | Byte program request |
| erase_req | input | 1 | Whole-array erase request |
| req_addr | input | ADDR_W | Program address |
| req_data | input | 8 | Program data |
| lock_en | input | 1 | Boot region lock enabled |
| lock_ovr | input | 1 | Lock override |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data or status, registered |
| busy_n | output | 1 | Low while an operation runs |
| done | output | 1 | One-cycle completion pulse |

## Verification
A request sampled at a rising edge drives `busy_n` low at the next falling edge. The bench counts falling edges with `busy_n` low and compares the count with PROG_CYC, or with ERASE_CYC plus the depth for an erase. It expects `done` at the first falling edge where `busy_n` is high again, and expects `done` to be low one edge later. Reads are driven at a falling edge and checked at the following falling edge. The bench decides whether to expect status or array data from the `busy_n` value it saw when it drove the read. Array results are checked only after `done`, against a bench model that applies AND for programs and 0xFF for erases, with the lock rule computed from the bench's own copy of the lock inputs.

// File: rtl/nwe_pkg.sv
package nwe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_EWAIT = 2'd2,
    ST_SWEEP = 2'd3
  } eng_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/nwe_timer.sv
module nwe_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nwe_boot_guard.sv
module nwe_boot_guard #(
  parameter int unsigned ADDR_W   = 10,
  parameter bit          TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock_en,
  input  logic              lock_ovr,
  output logic              blocked
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned BOOT_N = (DEPTH >= 64) ? DEPTH / 64 : 1;

  logic in_region;

  generate
    if (TOP_BOOT) begin : g_top
      localparam logic [ADDR_W-1:0] LOW_EDGE = ADDR_W'(DEPTH - BOOT_N);
      assign in_region = (addr >= LOW_EDGE);
    end else begin : g_bottom
      localparam logic [ADDR_W-1:0] HIGH_EDGE = ADDR_W'(BOOT_N);
      assign in_region = (addr < HIGH_EDGE);
    end
  endgenerate

  assign blocked = in_region & lock_en & ~lock_ovr;
endmodule

// File: rtl/nwe_array.sv
module nwe_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              and_mode,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      if (and_mode) mem[waddr] <= mem[waddr] & wdata;
      else          mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nwe_status.sv
module nwe_status #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          busy,
  input  logic          poll7,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] rd_q, rd_d;
  logic          tgl_q, tgl_d;

  always_comb begin
    rd_d  = rd_q;
    tgl_d = tgl_q;
    if (rd_en) begin
      if (busy) begin
        rd_d  = {poll7, tgl_q, {(DW-2){1'b0}}};
        tgl_d = ~tgl_q;
      end else begin
        rd_d  = arr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      tgl_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      tgl_q <= tgl_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/nwe_engine.sv
module nwe_engine
  import nwe_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned PROG_CYC  = 6,
  parameter int unsigned ERASE_CYC = 40,
  parameter bit          TOP_BOOT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              lock_en,
  input  logic              lock_ovr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy_n,
  output logic              done
);
  localparam int unsigned MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYC - 1);

  eng_state_t         st_q, st_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [7:0]         data_q, data_d;
  logic [ADDR_W-1:0]  sweep_q, sweep_d;
  logic               done_q, done_d;

  logic               tmr_load, tmr_run, tmr_zero;
  logic [CW-1:0]      tmr_val;
  logic               blk_req, blk_sweep;
  logic               mem_we, mem_and;
  logic [ADDR_W-1:0]  mem_waddr;
  logic [7:0]         mem_wdata, mem_rdata;
  logic               busy, poll7;

  nwe_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .zero(tmr_zero)
  );

  nwe_boot_guard #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_guard_req (
    .addr(req_addr), .lock_en(lock_en), .lock_ovr(lock_ovr), .blocked(blk_req)
  );

  nwe_boot_guard #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_guard_sweep (
    .addr(sweep_q), .lock_en(lock_en), .lock_ovr(lock_ovr), .blocked(blk_sweep)
  );

  nwe_array #(.ADDR_W(ADDR_W), .DW(BYTE_W)) u_array (
    .clk(clk), .we(mem_we), .and_mode(mem_and), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(rd_addr), .rdata(mem_rdata)
  );

  assign busy  = (st_q != ST_IDLE);
  assign poll7 = (st_q == ST_PROG) ? ~data_q[7] : 1'b0;

  nwe_status #(.DW(BYTE_W)) u_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy), .poll7(poll7),
    .arr_data(mem_rdata), .rd_data(rd_data)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    data_d    = data_q;
    sweep_d   = sweep_q;
    done_d    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = PROG_LD;
    tmr_run   = (st_q == ST_PROG) || (st_q == ST_EWAIT);
    mem_we    = 1'b0;
    mem_and   = 1'b0;
    mem_waddr = addr_q;
    mem_wdata = data_q;
    unique case (st_q)
      ST_IDLE: begin
        if (prog_req) begin
          if (!blk_req) begin
            st_d     = ST_PROG;
            addr_d   = req_addr;
            data_d   = req_data;
            tmr_load = 1'b1;
            tmr_val  = PROG_LD;
          end
        end else if (erase_req) begin
          st_d     = ST_EWAIT;
          tmr_load = 1'b1;
          tmr_val  = ERASE_LD;
        end
      end
      ST_PROG: begin
        if (tmr_zero) begin
          mem_we  = 1'b1;
          mem_and = 1'b1;
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_EWAIT: begin
        if (tmr_zero) begin
          st_d    = ST_SWEEP;
          sweep_d = '0;
        end
      end
      ST_SWEEP: begin
        mem_we    = ~blk_sweep;
        mem_waddr = sweep_q;
        mem_wdata = ERASED_BYTE;
        if (&sweep_q) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          sweep_d = sweep_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      sweep_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      sweep_q <= sweep_d;
      done_q  <= done_d;
    end
  end

  assign busy_n = ~busy;
  assign done   = done_q;
endmodule

// File: rtl/nwe_checker.sv
module nwe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       busy_n,
  input logic       done,
  input logic [7:0] rd_data
);
  logic stat_rd_q, have_prev_q, prev6_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_rd_q   <= 1'b0;
      have_prev_q <= 1'b0;
      prev6_q     <= 1'b0;
    end else begin
      stat_rd_q <= rd_en & ~busy_n;
      if (stat_rd_q) begin
        have_prev_q <= 1'b1;
        prev6_q     <= rd_data[6];
      end
    end
  end

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_n && $past(!busy_n)));

  p_busy_end_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> done);

  p_status_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy_n) |=> (rd_data[5:0] == 6'd0));

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_q && have_prev_q) |-> (rd_data[6] != prev6_q));
endmodule

bind nwe_engine nwe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy_n(busy_n),
  .done(done), .rd_data(rd_data)
);

// File: tb/tb_nwe_engine.sv
module tb_nwe_engine;
  localparam int unsigned AW        = 10;
  localparam int unsigned DEPTH     = 1 << AW;
  localparam int unsigned BOOT_N    = DEPTH / 64;
  localparam int unsigned PROG_CYC  = 6;
  localparam int unsigned ERASE_CYC = 40;
  localparam bit          TOP_BOOT  = 1'b0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_req, erase_req, lock_en, lock_ovr, rd_en;
  logic [AW-1:0] req_addr, rd_addr;
  logic [7:0]    req_data, rd_data;
  logic          busy_n, done;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;
  logic [7:0] model [DEPTH];
  logic tgl_m;

  always #2.5 clk = ~clk;

  nwe_engine #(.ADDR_W(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
               .TOP_BOOT(TOP_BOOT)) dut (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
    .req_addr(req_addr), .req_data(req_data), .lock_en(lock_en),
    .lock_ovr(lock_ovr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy_n(busy_n), .done(done)
  );

  function automatic bit in_boot(input logic [AW-1:0] a);
    if (TOP_BOOT) return int'(a) >= int'(DEPTH - BOOT_N);
    else          return int'(a) < int'(BOOT_N);
  endfunction

  function automatic bit blocked(input logic [AW-1:0] a);
    return in_boot(a) && lock_en && !lock_ovr;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data === model[a], req, int'(rd_data), int'(model[a]));
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < int'(DEPTH); i++) read_chk(AW'(i), req);
  endtask

  // Issues a request, reads status while busy, checks length and done.
  task automatic run_op(input bit is_erase, input logic [AW-1:0] a,
                        input logic [7:0] d, input bit poke, input bit both);
    int n;
    int exp_len;
    bit ign;
    logic [7:0] exp_st;
    @(negedge clk);
    prog_req  = !is_erase;
    erase_req = is_erase || both;
    req_addr  = a;
    req_data  = d;
    ign = !is_erase && blocked(a);
    @(negedge clk);
    prog_req = 1'b0; erase_req = 1'b0;
    if (ign) begin
      check(busy_n === 1'b1 && done === 1'b0, "R7 blocked program starts nothing",
            int'({busy_n, done}), 2);
      return;
    end
    exp_len = is_erase ? int'(ERASE_CYC + DEPTH) : int'(PROG_CYC);
    n = 0;
    while (busy_n === 1'b0 && n < exp_len + 10) begin
      rd_en = 1'b1; rd_addr = AW'($urandom);
      if (poke && n == 2) begin
        prog_req = 1'b1; req_addr = a ^ AW'(1); req_data = 8'h00;
      end
      @(negedge clk);
      rd_en = 1'b0; prog_req = 1'b0;
      exp_st = {(is_erase ? 1'b0 : ~d[7]), tgl_m, 6'b0};
      tgl_m = ~tgl_m;
      check(rd_data === exp_st, "R3/R4 status byte while busy", int'(rd_data), int'(exp_st));
      n++;
    end
    check(n == exp_len, both ? "R9 program wins, R5 busy length" : "R5 busy length",
          n, exp_len);
    check(done === 1'b1, "R6 done with busy release", int'(done), 1);
    if (is_erase) begin
      for (int i = 0; i < int'(DEPTH); i++)
        if (!blocked(AW'(i))) model[i] = 8'hFF;
    end else begin
      model[a] = model[a] & d;
    end
    @(negedge clk);
    check(done === 1'b0, "R6 done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; prog_req = 0; erase_req = 0; lock_en = 0; lock_ovr = 0;
    rd_en = 0; req_addr = '0; rd_addr = '0; req_data = '0; tgl_m = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_n === 1'b1 && done === 1'b0 && rd_data === 8'h00, "R10 reset state",
          int'({busy_n, done, rd_data}), 'h200);
    rst_n = 1'b1;

    // Clean erase, everything to 0xFF
    run_op(1'b1, '0, 8'h00, 1'b0, 1'b0);
    verify_all("R2/R11 erase result");

    // AND semantics
    run_op(1'b0, AW'(100), 8'hA5, 1'b0, 1'b0);
    read_chk(AW'(100), "R1 first program");
    run_op(1'b0, AW'(100), 8'h3C, 1'b0, 1'b0);
    read_chk(AW'(100), "R1 second program ANDs");
    run_op(1'b0, AW'(0), 8'h12, 1'b0, 1'b0);
    read_chk(AW'(0), "R8 boot programmable while unlocked");

    // Lock the boot region
    lock_en = 1'b1;
    run_op(1'b0, AW'(1), 8'h00, 1'b0, 1'b0);
    read_chk(AW'(1), "R7 blocked program leaves byte");
    run_op(1'b0, TOP_BOOT ? AW'(DEPTH - 1) : AW'(BOOT_N - 1), 8'h00, 1'b0, 1'b0);
    read_chk(TOP_BOOT ? AW'(DEPTH - 1) : AW'(BOOT_N - 1), "R7 last boot address blocked");
    run_op(1'b0, TOP_BOOT ? AW'(DEPTH - BOOT_N - 1) : AW'(BOOT_N), 8'h5A, 1'b0, 1'b0);
    read_chk(TOP_BOOT ? AW'(DEPTH - BOOT_N - 1) : AW'(BOOT_N), "R7 first open address");
    run_op(1'b1, '0, 8'h00, 1'b0, 1'b0);
    verify_all("R7 locked erase keeps boot");

    // Override
    lock_ovr = 1'b1;
    run_op(1'b0, AW'(2), 8'h0F, 1'b0, 1'b0);
    read_chk(AW'(2), "R8 override program");
    lock_ovr = 1'b0;

    // Requests while busy, simultaneous requests
    run_op(1'b0, AW'(300), 8'h77, 1'b1, 1'b0);
    read_chk(AW'(301), "R9 request during busy ignored");
    read_chk(AW'(300), "R1 program after poke");
    run_op(1'b0, AW'(400), 8'hC3, 1'b0, 1'b1);
    read_chk(AW'(401), "R9 simultaneous erase dropped");

    // Random programs under random lock settings
    for (int k = 0; k < 150; k++) begin
      lock_en  = 1'($urandom);
      lock_ovr = 1'($urandom);
      run_op(1'b0, ($urandom % 4 == 0) ? AW'($urandom % BOOT_N) : AW'($urandom),
             8'($urandom), 1'($urandom), 1'b0);
      if (k % 10 == 0) read_chk(AW'($urandom), "R11 random idle read");
    end
    verify_all("R1 random program image");

    // Reset in the middle of a program
    @(negedge clk);
    prog_req = 1'b1; req_addr = AW'(500); req_data = 8'h00; lock_en = 1'b0;
    @(negedge clk);
    prog_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy_n === 1'b1 && done === 1'b0 && rd_data === 8'h00, "R10 reset aborts",
          int'({busy_n, done, rd_data}), 'h200);
    tgl_m = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_op(1'b1, '0, 8'h00, 1'b0, 1'b0);
    verify_all("R10 erase after abort");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule